// File: doc/BRIEF.md
# Shared Unit Ownership Lock

The block decides which media engine owns each of a set of shared post-processing units. There are `NUM_UNITS` shared units and three engines per unit: two decode engines and one enhancement engine. An engine holds its request line high to ask for its unit. It sees ownership on its usage output, which is registered and asserts on the edge after the unit is granted. It gives the unit back by dropping the request.

Before software resets an engine, it raises that engine's forced-lock input. Forcing freezes the engine's ownership state. An engine that already owns its unit keeps it, even if its request falls. An engine that does not own its unit cannot acquire it. After a fixed delay the engine's acknowledge output confirms the freeze. Software then reads the usage bit to decide whether the shared unit must be reset along with the engine. The per-unit reset input drops that unit's ownership, and clearing forced lock lets the engine take part in arbitration again.

Top module: `shared_unit_lock`

## Requirements
- R1: While rst_ni is low, and right after it rises, every usage_o bit and every ack_o bit is 0.
- R2: Engine indices are fixed. Indices 0 to 2*NUM_UNITS-1 are decode engines, and decode engine i uses unit i>>1. Indices 2*NUM_UNITS to 3*NUM_UNITS-1 are enhancement engines, and enhancement engine 2*NUM_UNITS+k uses unit k. Different units are arbitrated independently and can be granted in the same cycle.
- R3: Suppose a unit is free and not being reset, and at least one of its engines requests it with forced lock low. Then exactly one of those engines has usage_o at 1 after the next clock edge. A unit never has more than one owner.
- R4: When several eligible engines request the same free unit in one cycle, the lowest engine index wins. For unit k the order is decode 2k, then decode 2k+1, then enhancement 2*NUM_UNITS+k.
- R5: An owner whose request and forced lock are both low loses usage_o on the next edge.
- R6: An owner whose forced lock is high keeps usage_o even with its request low, until forced lock falls or its unit is reset.
- R7: An engine whose forced lock is high and which does not own its unit never gains usage_o. This holds even when the unit is free and the engine is requesting it.
- R8: ack_o of an engine rises on the second clock edge after forced lock goes high. It stays high while forced lock stays high, and it is 0 after the first edge at which forced lock is low.
- R9: While an engine's ack_o and forced lock are both high, its usage_o does not change unless its unit is reset.
- R10: When unit_rst_i[k] is high at an edge, unit k has no owner after that edge. No grant is made to unit k at that edge, and the other units are not affected.
- R11: Once forced lock is cleared, the engine's requests are honoured again, starting at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3*NUM_UNITS | Lock request, one bit per engine (level) |
| force_i | input | 3*NUM_UNITS | Forced-lock request, one bit per engine |
| unit_rst_i | input | NUM_UNITS | Clears ownership of the matching shared unit |
| usage_o | output | 3*NUM_UNITS | Engine currently owns its shared unit |
| ack_o | output | 3*NUM_UNITS | Forced lock has taken effect for the engine |

## Verification
Arbitration is first driven with single requesters, then with three-way contention on one unit, then with requests from staggered releases. These patterns separate the plain grant, the fixed priority order and the release path. Requests to both units in the same cycle show that the two units are independent. Forced lock is applied twice, once to an owner and once to a non-owner. This separates the hold and refuse behaviours, and it shows that the acknowledge timing and the frozen usage stay in place while another engine contends. Unit reset is applied to an owned unit while a force is active, and to a free unit with a pending request. These two cases show that the reset clears only its own unit and takes precedence over a new grant.

// File: rtl/shared_unit_lock_pkg.sv
package shared_unit_lock_pkg;
  localparam int unsigned SLOTS  = 3;
  localparam int unsigned SLOT_W = 2;

  // unit reached by global engine index e
  function automatic int unsigned unit_of(int unsigned e, int unsigned nu);
    return (e < 2 * nu) ? (e >> 1) : (e - 2 * nu);
  endfunction

  // arbitration slot of engine e within its unit (0 = highest priority)
  function automatic int unsigned slot_of(int unsigned e, int unsigned nu);
    return (e < 2 * nu) ? (e & 1) : 2;
  endfunction
endpackage

// File: rtl/sul_force_ctl.sv
module sul_force_ctl #(
  parameter int unsigned ACK_DELAY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  output logic ack_o
);
  localparam int unsigned CW = $clog2(ACK_DELAY + 1);
  localparam logic [CW-1:0] FULL = CW'(ACK_DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!force_i)    cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign ack_o = (cnt_q == FULL);
endmodule

// File: rtl/sul_unit_arb.sv
module sul_unit_arb
  import shared_unit_lock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] req_i,
  input  logic [SLOTS-1:0] force_i,
  input  logic             unit_rst_i,
  output logic [SLOTS-1:0] own_o
);
  logic              own_vld_q;
  logic [SLOT_W-1:0] own_slot_q;
  logic [SLOTS-1:0]  cand;
  logic              pick_vld;
  logic [SLOT_W-1:0] pick;

  // forced engines may not acquire
  assign cand = req_i & ~force_i;

  // fixed priority: lowest slot wins
  always_comb begin
    pick_vld = 1'b0;
    pick     = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (cand[s]) begin
        pick_vld = 1'b1;
        pick     = SLOT_W'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q  <= 1'b0;
      own_slot_q <= '0;
    end else if (unit_rst_i) begin
      own_vld_q  <= 1'b0;
    end else if (own_vld_q) begin
      // forced owner cannot release
      if (!req_i[own_slot_q] && !force_i[own_slot_q]) own_vld_q <= 1'b0;
    end else if (pick_vld) begin
      own_vld_q  <= 1'b1;
      own_slot_q <= pick;
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) own_o[s] = own_vld_q && (own_slot_q == SLOT_W'(s));
  end
endmodule

// File: rtl/shared_unit_lock.sv
module shared_unit_lock
  import shared_unit_lock_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 2,
  parameter int unsigned ACK_DELAY = 2,
  localparam int unsigned NUM_ENG  = 3 * NUM_UNITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_ENG-1:0]   req_i,
  input  logic [NUM_ENG-1:0]   force_i,
  input  logic [NUM_UNITS-1:0] unit_rst_i,
  output logic [NUM_ENG-1:0]   usage_o,
  output logic [NUM_ENG-1:0]   ack_o
);
  localparam int unsigned NUM_DEC = 2 * NUM_UNITS;

  logic [NUM_UNITS-1:0][SLOTS-1:0] u_req, u_frc, u_own;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    assign u_req[k] = {req_i[NUM_DEC+k], req_i[2*k+1], req_i[2*k]};
    assign u_frc[k] = {force_i[NUM_DEC+k], force_i[2*k+1], force_i[2*k]};

    sul_unit_arb u_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (u_req[k]),
      .force_i    (u_frc[k]),
      .unit_rst_i (unit_rst_i[k]),
      .own_o      (u_own[k])
    );
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    localparam int unsigned U = unit_of(e, NUM_UNITS);
    localparam int unsigned S = slot_of(e, NUM_UNITS);

    assign usage_o[e] = u_own[U][S];

    sul_force_ctl #(.ACK_DELAY(ACK_DELAY)) u_frc_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .force_i (force_i[e]),
      .ack_o   (ack_o[e])
    );
  end
endmodule

// File: rtl/shared_unit_lock_chk.sv
module shared_unit_lock_chk
  import shared_unit_lock_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 2,
  parameter int unsigned ACK_DELAY = 2,
  localparam int unsigned NUM_ENG  = 3 * NUM_UNITS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_ENG-1:0]   req_i,
  input logic [NUM_ENG-1:0]   force_i,
  input logic [NUM_UNITS-1:0] unit_rst_i,
  input logic [NUM_ENG-1:0]   usage_o,
  input logic [NUM_ENG-1:0]   ack_o
);
  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_u
    // R3
    one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({usage_o[2*NUM_UNITS+k], usage_o[2*k+1], usage_o[2*k]}));
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_e
    localparam int unsigned U = unit_of(e, NUM_UNITS);

    // R5
    release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      usage_o[e] && !req_i[e] && !force_i[e] |=> !usage_o[e]);
    // R6
    hold_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      usage_o[e] && force_i[e] && !unit_rst_i[U] |=> usage_o[e]);
    // R7
    refuse_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !usage_o[e] && force_i[e] |=> !usage_o[e]);
    // R8
    ack_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_o[e]) |-> $past(force_i[e]) && $past(force_i[e], 2));
    // R8
    ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !force_i[e] |=> !ack_o[e]);
    // R9
    frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o[e] && force_i[e] && !unit_rst_i[U] |=> $stable(usage_o[e]));
    // R10
    unit_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unit_rst_i[U] |=> !usage_o[e]);
  end
endmodule

bind shared_unit_lock shared_unit_lock_chk #(.NUM_UNITS(NUM_UNITS), .ACK_DELAY(ACK_DELAY)) u_chk (.*);

// File: tb/sim_shared_unit_lock.sv
module sim_shared_unit_lock;
  localparam int NU = 2;
  localparam int NE = 3 * NU;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NE-1:0] req_i = '0;
  logic [NE-1:0] force_i = '0;
  logic [NU-1:0] unit_rst_i = '0;
  logic [NE-1:0] usage_o, ack_o;

  always #5 clk_i = ~clk_i;

  shared_unit_lock #(.NUM_UNITS(NU)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .force_i(force_i),
    .unit_rst_i(unit_rst_i), .usage_o(usage_o), .ack_o(ack_o)
  );

  typedef struct {
    logic [NE-1:0] usage;
    logic [NE-1:0] ack;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int   n_run = 0;
  int   n_fail = 0;

  function automatic void check(string tag, logic [NE-1:0] au, logic [NE-1:0] eu,
                                logic [NE-1:0] aa, logic [NE-1:0] ea);
    n_run++;
    if (au !== eu || aa !== ea) begin
      n_fail++;
      $display("FAIL %s: usage=%b exp %b, ack=%b exp %b", tag, au, eu, aa, ea);
    end
  endfunction

  // monitor: compare after each edge
  initial begin
    forever begin
      exp_t x;
      @(posedge clk_i);
      #2;
      if (sb.size() > 0) begin
        x = sb.pop_front();
        check(x.tag, usage_o, x.usage, ack_o, x.ack);
      end
    end
  end

  // driver: inputs for the next edge plus the expected result after it
  task automatic step(input logic [NE-1:0] r, input logic [NE-1:0] f, input logic [NU-1:0] u,
                      input logic [NE-1:0] eu, input logic [NE-1:0] ea, input string tag);
    @(negedge clk_i);
    req_i = r;
    force_i = f;
    unit_rst_i = u;
    sb.push_back('{usage: eu, ack: ea, tag: tag});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", usage_o, '0, ack_o, '0);
    rst_ni = 1'b1;
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R1 after reset");
    // plain grant and release
    step(6'b000001, 6'b000000, 2'b00, 6'b000001, 6'b000000, "R3 single grant");
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 release");
    // contention on unit 0: engines 0, 1, 4
    step(6'b010011, 6'b000000, 2'b00, 6'b000001, 6'b000000, "R4 decode lo wins");
    step(6'b010010, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 owner drops");
    step(6'b010010, 6'b000000, 2'b00, 6'b000010, 6'b000000, "R4 decode hi next");
    step(6'b010000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 owner drops");
    step(6'b010000, 6'b000000, 2'b00, 6'b010000, 6'b000000, "R4 enhancement last");
    // independent units
    step(6'b010100, 6'b000000, 2'b00, 6'b010100, 6'b000000, "R2 unit1 via decode 2");
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 both release");
    step(6'b100010, 6'b000000, 2'b00, 6'b100010, 6'b000000, "R2 same-cycle grants");
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 both release");
    // forced lock on an owner
    step(6'b000001, 6'b000000, 2'b00, 6'b000001, 6'b000000, "R3 grant engine 0");
    step(6'b000000, 6'b000001, 2'b00, 6'b000001, 6'b000000, "R6 held, ack pending");
    step(6'b000000, 6'b000001, 2'b00, 6'b000001, 6'b000001, "R8 ack after two edges");
    step(6'b000000, 6'b000001, 2'b00, 6'b000001, 6'b000001, "R6 still held");
    step(6'b000010, 6'b000001, 2'b00, 6'b000001, 6'b000001, "R9 frozen under contention");
    step(6'b000010, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R8 ack clears, owner releases");
    step(6'b000010, 6'b000000, 2'b00, 6'b000010, 6'b000000, "R11 requests honoured");
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 release");
    // forced lock on a non-owner
    step(6'b000010, 6'b000010, 2'b00, 6'b000000, 6'b000000, "R7 refused");
    step(6'b000010, 6'b000010, 2'b00, 6'b000000, 6'b000010, "R7 refused, R8 ack");
    step(6'b010010, 6'b000010, 2'b00, 6'b010000, 6'b000010, "R7 lower priority wins");
    step(6'b000010, 6'b000010, 2'b00, 6'b000000, 6'b000010, "R7 free unit still refused");
    step(6'b000010, 6'b000010, 2'b00, 6'b000000, 6'b000010, "R7 refused again");
    step(6'b000010, 6'b000000, 2'b00, 6'b000010, 6'b000000, "R11 grant after clear");
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 release");
    // unit reset
    step(6'b000101, 6'b000000, 2'b00, 6'b000101, 6'b000000, "R2 two owners");
    step(6'b000101, 6'b000001, 2'b00, 6'b000101, 6'b000000, "R6 forced owner");
    step(6'b000101, 6'b000001, 2'b00, 6'b000101, 6'b000001, "R8 ack");
    step(6'b000101, 6'b000001, 2'b01, 6'b000100, 6'b000001, "R10 unit0 cleared only");
    step(6'b000101, 6'b000001, 2'b00, 6'b000100, 6'b000001, "R7 no reacquire while forced");
    step(6'b000101, 6'b000000, 2'b10, 6'b000001, 6'b000000, "R10 unit1 cleared, R11 unit0 regrant");
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 release");
    step(6'b000100, 6'b000000, 2'b10, 6'b000000, 6'b000000, "R10 reset beats grant");
    step(6'b000100, 6'b000000, 2'b00, 6'b000100, 6'b000000, "R3 grant after reset");
    step(6'b000000, 6'b000000, 2'b00, 6'b000000, 6'b000000, "R5 release");
    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run not done, expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule